// File: doc/BRIEF.md
# Transmit Frame Builder

The block lays out one outgoing Ethernet frame inside the packet memory of a network controller. A client pulses `start` with the frame length in bytes. The block first asks the controller's memory manager for a buffer and waits for the grant. If the grant does not arrive in time, the block resets the memory manager and asks once more. It then selects the granted packet and sets the access pointer to write with auto-increment. The image it writes has this layout: two zero control bytes, a 16-bit byte count sent low byte first, the frame bytes pulled one per cycle from a byte source, a zero pad byte when the length is odd, and a closing zero control word. The block finishes by queuing the packet for transmission.

A frame whose network-layer payload exceeds the limit is refused at once. The payload is the frame length less a fixed link-layer header. Every attempt ends in a one-cycle `done` pulse or a one-cycle `error` pulse. The transmit engine and checksum generation lie outside the block.

Top module: `txfb_top`

## Requirements
- R1: When `frame_len` is larger than `MAX_PAYLOAD + HDR_BYTES`, `error` pulses on the cycle after `start`. In that case no command is issued and nothing is written.
- R2: An accepted frame first issues command code 0x20 (allocate). The block then waits until `mmu_busy` is low and `alloc_done` is high, and this wait lasts at most `TIMEOUT` cycles.
- R3: If the first allocate wait times out, the block issues command 0x40 (memory reset). It waits for `mmu_busy` low, also for at most `TIMEOUT` cycles, and then issues 0x20 again. A second allocate timeout, or a reset-wait timeout, ends the attempt with `error` and issues no further command.
- R4: After the grant, the block writes register select 0 (packet number) with `alloc_pkt` zero-extended. It then writes register select 1 (pointer) with 0x4000.
- R5: All image bytes are written one per cycle to register select 2 (data) on `wr_data[7:0]`, in this order: 0x00, 0x00, count low, count high, the frame bytes in source order, one 0x00 pad byte only when `frame_len` is odd, then 0x00, 0x00.
- R6: The byte count written is `frame_len + 6`, plus one when that sum is odd.
- R7: After the image, the block waits for `mmu_busy` low for at most `TIMEOUT` cycles and then issues command 0xC0 (enqueue). The enqueue is never issued in a cycle that follows a busy cycle. If this wait times out, the attempt ends with `error` and no enqueue is issued.
- R8: `done` follows the enqueue by one cycle. `done` and `error` each last exactly one cycle and never occur together.
- R9: A `start` that arrives while an attempt is in progress is ignored and leaves the current image unchanged.
- R10: While reset is held, `done`, `error`, `cmd_we`, `wr_en` and `src_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin building a frame |
| frame_len | input | LEN_W | Frame length in bytes, sampled with start |
| src_req | output | 1 | Frame byte consumed this cycle |
| src_data | input | 8 | Current frame byte from the source |
| wr_en | output | 1 | Buffer register write strobe |
| wr_reg | output | 2 | Register select: 0 packet number, 1 pointer, 2 data |
| wr_data | output | 16 | Write value (data bytes use bits 7:0) |
| cmd_we | output | 1 | Memory manager command strobe |
| cmd_code | output | 8 | Command code |
| mmu_busy | input | 1 | Memory manager busy flag |
| alloc_done | input | 1 | Allocation granted |
| alloc_pkt | input | PKT_W | Granted packet number |
| done | output | 1 | Frame queued (one-cycle pulse) |
| error | output | 1 | Attempt failed (one-cycle pulse) |

## Verification
On every cycle the assertions check three things: `done` and `error` are exclusive one-cycle pulses, the enqueue never directly follows a busy cycle, and the timeout counter stays in range. They also check that a frame byte is consumed only while a data byte is being written, and that an oversized request issues nothing. Only the bench scenarios can show the exact image contents and byte count for each length. The same holds for the command order along the retry and failure paths, and for the ignored restart. To cover these, the bench sweeps every length on both sides of the limit and compares against an image that it builds by arithmetic.

// File: rtl/txfb_pkg.sv
package txfb_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ALLOC_CMD,
        S_ALLOC_WAIT,
        S_RST_CMD,
        S_RST_WAIT,
        S_SET_PNR,
        S_SET_PTR,
        S_HDR,
        S_DATA,
        S_PAD,
        S_TAIL,
        S_ENQ_WAIT,
        S_ENQ_CMD
    } state_t;

    localparam logic [1:0] SEL_PKTNUM = 2'd0;
    localparam logic [1:0] SEL_PTR    = 2'd1;
    localparam logic [1:0] SEL_DATA   = 2'd2;

    localparam logic [7:0] CMD_ALLOC = 8'(1 << 5);
    localparam logic [7:0] CMD_RESET = 8'(2 << 5);
    localparam logic [7:0] CMD_ENQ   = 8'(6 << 5);

    localparam logic [15:0] PTR_AUTO_WRITE = 16'h4000;

    typedef struct packed {
        logic        we;
        logic [1:0]  sel;
        logic [15:0] data;
    } bufwr_t;

    typedef struct packed {
        logic       we;
        logic [7:0] code;
    } mmucmd_t;

    function automatic logic [15:0] image_count(input logic [15:0] len);
        logic [15:0] c;
        c = len + 16'd6;
        c = c + {15'd0, c[0]};
        return c;
    endfunction

endpackage

// File: rtl/txfb_sizer.sv
module txfb_sizer #(
    parameter int LEN_W     = 11,
    parameter int MAX_FRAME = 1514
) (
    input  logic [LEN_W-1:0] len,
    output logic             too_long,
    output logic             odd,
    output logic [15:0]      count
);
    import txfb_pkg::*;

    always_comb begin
        too_long = int'(len) > MAX_FRAME;
        odd      = len[0];
        count    = image_count(16'(len));
    end

endmodule

// File: rtl/txfb_timer.sv
module txfb_timer #(
    parameter int TIMEOUT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign expired = run && (cnt == LAST);

    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < TIMEOUT) else $error("timer out of range"); // R3

endmodule

// File: rtl/txfb_ctrl.sv
module txfb_ctrl #(
    parameter int LEN_W = 11,
    parameter int PKT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             too_long,
    input  logic             len_odd,
    input  logic [15:0]      len_count,
    input  logic             tmo,
    input  logic             mmu_busy,
    input  logic             alloc_done,
    input  logic [PKT_W-1:0] alloc_pkt,
    input  logic [7:0]       src_data,
    output logic             waiting,
    output logic             src_req,
    output txfb_pkg::bufwr_t  bw,
    output txfb_pkg::mmucmd_t mc,
    output logic             done,
    output logic             error
);
    import txfb_pkg::*;

    state_t           state;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] dcnt;
    logic [15:0]      count_q;
    logic             odd_q;
    logic             retried;
    logic [1:0]       idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            len_q   <= '0;
            dcnt    <= '0;
            count_q <= '0;
            odd_q   <= 1'b0;
            retried <= 1'b0;
            idx     <= '0;
            done    <= 1'b0;
            error   <= 1'b0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        if (too_long) begin
                            error <= 1'b1;
                        end else begin
                            len_q   <= frame_len;
                            count_q <= len_count;
                            odd_q   <= len_odd;
                            retried <= 1'b0;
                            state   <= S_ALLOC_CMD;
                        end
                    end
                end
                S_ALLOC_CMD: state <= S_ALLOC_WAIT;
                S_ALLOC_WAIT: begin
                    if (!mmu_busy && alloc_done) begin
                        state <= S_SET_PNR;
                    end else if (tmo) begin
                        if (retried) begin
                            error <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            retried <= 1'b1;
                            state   <= S_RST_CMD;
                        end
                    end
                end
                S_RST_CMD: state <= S_RST_WAIT;
                S_RST_WAIT: begin
                    if (!mmu_busy) begin
                        state <= S_ALLOC_CMD;
                    end else if (tmo) begin
                        error <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_SET_PNR: state <= S_SET_PTR;
                S_SET_PTR: begin
                    idx   <= '0;
                    state <= S_HDR;
                end
                S_HDR: begin
                    idx <= idx + 2'd1;
                    if (idx == 2'd3) begin
                        idx   <= '0;
                        dcnt  <= '0;
                        state <= (len_q == '0) ? S_TAIL : S_DATA;
                    end
                end
                S_DATA: begin
                    dcnt <= dcnt + LEN_W'(1);
                    if (dcnt == len_q - LEN_W'(1)) begin
                        idx   <= '0;
                        state <= odd_q ? S_PAD : S_TAIL;
                    end
                end
                S_PAD: begin
                    idx   <= '0;
                    state <= S_TAIL;
                end
                S_TAIL: begin
                    idx <= idx + 2'd1;
                    if (idx == 2'd1) state <= S_ENQ_WAIT;
                end
                S_ENQ_WAIT: begin
                    if (!mmu_busy) begin
                        state <= S_ENQ_CMD;
                    end else if (tmo) begin
                        error <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_ENQ_CMD: begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        bw      = '0;
        mc      = '0;
        src_req = 1'b0;
        waiting = (state == S_ALLOC_WAIT) || (state == S_RST_WAIT) ||
                  (state == S_ENQ_WAIT);
        case (state)
            S_ALLOC_CMD: mc = '{we: 1'b1, code: CMD_ALLOC};
            S_RST_CMD:   mc = '{we: 1'b1, code: CMD_RESET};
            S_ENQ_CMD:   mc = '{we: 1'b1, code: CMD_ENQ};
            S_SET_PNR:   bw = '{we: 1'b1, sel: SEL_PKTNUM, data: 16'(alloc_pkt)};
            S_SET_PTR:   bw = '{we: 1'b1, sel: SEL_PTR, data: PTR_AUTO_WRITE};
            S_HDR: begin
                bw.we  = 1'b1;
                bw.sel = SEL_DATA;
                case (idx)
                    2'd2:    bw.data = {8'd0, count_q[7:0]};
                    2'd3:    bw.data = {8'd0, count_q[15:8]};
                    default: bw.data = 16'd0;
                endcase
            end
            S_DATA: begin
                bw      = '{we: 1'b1, sel: SEL_DATA, data: {8'd0, src_data}};
                src_req = 1'b1;
            end
            S_PAD, S_TAIL: bw = '{we: 1'b1, sel: SEL_DATA, data: 16'd0};
            default: ;
        endcase
    end

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && error)) else $error("done with error"); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done held"); // R8
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        error |=> !error) else $error("error held"); // R8
    AST_ENQ_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (mc.we && mc.code == CMD_ENQ) |-> $past(!mmu_busy)) else $error("enqueue while busy"); // R7
    AST_SRC_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        src_req |-> (bw.we && bw.sel == SEL_DATA && !mc.we)) else $error("stray source pull"); // R5
    AST_LONG_NO_CMD: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && start && too_long) |=> (!mc.we && !bw.we && error)) else $error("oversize accepted"); // R1
    AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && state != S_ENQ_CMD && !error) |=> $stable(len_q)) else $error("length changed"); // R9

endmodule

// File: rtl/txfb_top.sv
module txfb_top #(
    parameter int LEN_W       = 11,
    parameter int PKT_W       = 6,
    parameter int MAX_PAYLOAD = 1500,
    parameter int HDR_BYTES   = 14,
    parameter int TIMEOUT     = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    output logic             src_req,
    input  logic [7:0]       src_data,
    output logic             wr_en,
    output logic [1:0]       wr_reg,
    output logic [15:0]      wr_data,
    output logic             cmd_we,
    output logic [7:0]       cmd_code,
    input  logic             mmu_busy,
    input  logic             alloc_done,
    input  logic [PKT_W-1:0] alloc_pkt,
    output logic             done,
    output logic             error
);
    import txfb_pkg::*;

    localparam int MAX_FRAME = MAX_PAYLOAD + HDR_BYTES;

    logic        too_long;
    logic        len_odd;
    logic [15:0] len_count;
    logic        waiting;
    logic        tmo;
    bufwr_t      bw;
    mmucmd_t     mc;

    txfb_sizer #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_sizer (
        .len      (frame_len),
        .too_long (too_long),
        .odd      (len_odd),
        .count    (len_count)
    );

    txfb_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (waiting),
        .expired (tmo)
    );

    txfb_ctrl #(.LEN_W(LEN_W), .PKT_W(PKT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .frame_len  (frame_len),
        .too_long   (too_long),
        .len_odd    (len_odd),
        .len_count  (len_count),
        .tmo        (tmo),
        .mmu_busy   (mmu_busy),
        .alloc_done (alloc_done),
        .alloc_pkt  (alloc_pkt),
        .src_data   (src_data),
        .waiting    (waiting),
        .src_req    (src_req),
        .bw         (bw),
        .mc         (mc),
        .done       (done),
        .error      (error)
    );

    assign wr_en    = bw.we;
    assign wr_reg   = bw.sel;
    assign wr_data  = bw.data;
    assign cmd_we   = mc.we;
    assign cmd_code = mc.code;

    AST_NO_WR_CMD_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && cmd_we)) else $error("write and command together"); // R5

endmodule

// File: tb/txfb_top_tb.sv
module txfb_top_tb;
    localparam int LEN_W = 6;
    localparam int PKT_W = 6;
    localparam int MAXP  = 20;
    localparam int HDR   = 14;
    localparam int TMO   = 8;
    localparam int MAXF  = MAXP + HDR;

    logic clk = 0;
    logic rst = 1;
    logic start = 0;
    logic [LEN_W-1:0] frame_len = '0;
    logic src_req, wr_en, cmd_we, done, error;
    logic [1:0] wr_reg;
    logic [15:0] wr_data;
    logic [7:0] cmd_code, src_data;
    logic mmu_busy, alloc_done;
    logic [PKT_W-1:0] alloc_pkt;

    txfb_top #(.LEN_W(LEN_W), .PKT_W(PKT_W), .MAX_PAYLOAD(MAXP),
               .HDR_BYTES(HDR), .TIMEOUT(TMO)) u_dut (
        .clk(clk), .rst(rst), .start(start), .frame_len(frame_len),
        .src_req(src_req), .src_data(src_data), .wr_en(wr_en), .wr_reg(wr_reg),
        .wr_data(wr_data), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .mmu_busy(mmu_busy), .alloc_done(alloc_done), .alloc_pkt(alloc_pkt),
        .done(done), .error(error));

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    bit finished = 0;

    // responder and capture state
    int busy_left = 0;
    bit stuck = 0;
    bit enq_stuck = 0;
    int fail_left = 0;
    bit grant = 0;
    int src_idx = 0;
    int pkt_num = 0;
    logic [7:0] img [0:127];
    int img_n = 0;
    logic [7:0] cmds [0:15];
    int cmd_n = 0;
    int pnr_seen = -1, ptr_seen = -1;
    int ptr_order = 0, pnr_order = 0, wr_order = 0;

    assign mmu_busy   = (busy_left > 0) || stuck;
    assign alloc_done = grant;
    assign alloc_pkt  = PKT_W'(pkt_num);
    assign src_data   = 8'((src_idx * 37 + 11) & 255);

    always @(posedge clk) begin
        if (busy_left > 0) busy_left <= busy_left - 1;
        if (src_req) src_idx <= src_idx + 1;
        if (cmd_we) begin
            if (cmd_n < 16) cmds[cmd_n] <= cmd_code;
            cmd_n <= cmd_n + 1;
            if (cmd_code == 8'h20) begin
                busy_left <= 2;
                if (fail_left > 0) begin
                    fail_left <= fail_left - 1;
                    grant <= 0;
                end else begin
                    grant <= 1;
                end
            end else if (cmd_code == 8'h40) begin
                grant <= 0;
                busy_left <= 3;
            end else begin
                grant <= 0;
            end
        end
        if (wr_en) begin
            wr_order <= wr_order + 1;
            if (wr_reg == 2'd2) begin
                if (img_n < 128) img[img_n] <= wr_data[7:0];
                img_n <= img_n + 1;
            end else if (wr_reg == 2'd0) begin
                pnr_seen <= int'(wr_data);
                pnr_order <= wr_order;
            end else if (wr_reg == 2'd1) begin
                ptr_seen <= int'(wr_data);
                ptr_order <= wr_order;
                if (enq_stuck) stuck <= 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // fails_n: allocs that are not granted; kind 0 ok, 1 oversize, 2 alloc fail, 3 enqueue stuck
    task automatic run_frame(input int len, input int fails_n, input bit est,
                             input int kind, input int restart_at);
        int k;
        int odd, cnt, exp_n;
        bit got_done, got_err;
        @(negedge clk);
        img_n = 0; cmd_n = 0; pnr_seen = -1; ptr_seen = -1;
        wr_order = 0; src_idx = 0; stuck = 0; enq_stuck = est;
        fail_left = fails_n; pkt_num = (len * 5 + 3) % 64;
        start = 1; frame_len = LEN_W'(len);
        @(negedge clk);
        start = 0;
        got_done = 0; got_err = 0;
        for (k = 0; k < 400; k++) begin
            if (done || error) begin
                got_done = done; got_err = error;
                break;
            end
            if (restart_at != 0 && k == restart_at) begin
                start = 1; frame_len = LEN_W'(3);
            end else begin
                start = 0;
            end
            @(negedge clk);
        end
        start = 0;
        // R8 one-cycle pulse, exclusive
        chk(!(got_done && got_err), "R8", int'(got_done), 0);
        @(negedge clk);
        chk(!done && !error, "R8", int'(done) + int'(error), 0);
        odd = len & 1;
        cnt = len + 6 + odd;
        exp_n = 4 + len + odd + 2;
        if (kind == 1) begin
            chk(got_err && k == 0, "R1", k, 0);
            chk(cmd_n == 0 && img_n == 0, "R1", cmd_n + img_n, 0);
        end else if (kind == 2) begin
            chk(got_err, "R3", int'(got_err), 1);
            chk(cmd_n == 3, "R3", cmd_n, 3);
            chk(cmds[0] == 8'h20 && cmds[1] == 8'h40 && cmds[2] == 8'h20, "R3",
                int'(cmds[1]), 32'h40);
            chk(img_n == 0, "R3", img_n, 0);
        end else if (kind == 3) begin
            chk(got_err, "R7", int'(got_err), 1);
            chk(cmd_n == 1 && cmds[0] == 8'h20, "R7", cmd_n, 1);
            chk(img_n == exp_n, "R7", img_n, exp_n);
        end else begin
            chk(got_done, "R8", int'(got_done), 1);
            if (fails_n == 1) begin
                chk(cmd_n == 4 && cmds[0] == 8'h20 && cmds[1] == 8'h40 &&
                    cmds[2] == 8'h20 && cmds[3] == 8'hC0, "R3", cmd_n, 4);
            end else begin
                chk(cmd_n == 2 && cmds[0] == 8'h20, "R2", cmd_n, 2);
                chk(cmds[1] == 8'hC0, "R7", int'(cmds[1]), 32'hC0);
            end
            chk(pnr_seen == pkt_num, "R4", pnr_seen, pkt_num);
            chk(ptr_seen == 32'h4000 && pnr_order == 0 && ptr_order == 1, "R4",
                ptr_seen, 32'h4000);
            chk(img_n == exp_n, (restart_at != 0) ? "R9" : "R5", img_n, exp_n);
            chk(img[0] == 0 && img[1] == 0, "R5", int'(img[0]) + int'(img[1]), 0);
            chk({img[3], img[2]} == 16'(cnt), "R6", int'({img[3], img[2]}), cnt);
            for (int i = 0; i < len; i++) begin
                chk(img[4 + i] == 8'((i * 37 + 11) & 255), "R5",
                    int'(img[4 + i]), (i * 37 + 11) & 255);
            end
            if (odd == 1) chk(img[4 + len] == 0, "R5", int'(img[4 + len]), 0);
            chk(img[exp_n - 2] == 0 && img[exp_n - 1] == 0, "R5",
                int'(img[exp_n - 1]), 0);
        end
    endtask

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!done && !error && !cmd_we && !wr_en && !src_req, "R10",
            int'(done) + int'(error) + int'(cmd_we) + int'(wr_en), 0);
        rst = 0;
        @(negedge clk);
        // sweep every length around the limit (R5 R6 R1)
        for (int n = 0; n <= MAXF + 6; n++) begin
            run_frame(n, 0, 0, (n > MAXF) ? 1 : 0, 0);
        end
        // single allocation miss recovers (R3)
        run_frame(5, 1, 0, 0, 0);
        run_frame(MAXF, 1, 0, 0, 0);
        // two misses fail (R3)
        run_frame(7, 2, 0, 2, 0);
        // enqueue wait times out (R7)
        run_frame(9, 0, 1, 3, 0);
        // start during a frame is ignored (R9)
        run_frame(12, 0, 0, 0, 2);
        run_frame(11, 0, 0, 0, 10);
        // normal after failures (R2)
        run_frame(1, 0, 0, 0, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #3000000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule